// File: doc/BRIEF.md
# Reset Pulse-Width Classifier

This block watches an asynchronous, active-high reset pin and measures how long each pulse lasts, counted in system clock cycles. When the pulse ends, the block decides whether it was too short to matter, a partial reset, or a full reset. It then raises a one-cycle strobe for the outcome and holds a ready flag low for a setup holdoff that depends on the outcome. A conversion-start request that arrives while the flag is low is dropped and flagged.

When a counted reset pulse ends, and also when the power-on reset is removed, the block captures a 3-bit oversampling select and decodes it. Codes 0 to 6 give an oversampling ratio of 2 to the power of the code. Code 7 gives no ratio and sets a software-mode flag. All time limits are given in nanoseconds and converted to clock cycles from a clock-period parameter.

Top module: `rstw_classifier`

## Requirements
- R1: A pin pulse that leaves the synchronized reset high for fewer than ceil(IGNORE_BELOW_NS/CLK_PERIOD_NS) cycles produces no strobe. It leaves the oversampling ratio, the software-mode flag and the ready flag unchanged.
- R2: A pulse of at least that many cycles, and fewer than ceil(PARTIAL_BELOW_NS/CLK_PERIOD_NS) cycles, raises `part_rst_o` for exactly one cycle. The strobe comes two clocks after the last cycle in which the synchronized reset was high.
- R3: A pulse of ceil(PARTIAL_BELOW_NS/CLK_PERIOD_NS) cycles or longer raises `full_rst_o` for exactly one cycle, with the same timing as R2. This includes the undefined band up to 3 µs.
- R4: `part_rst_o` and `full_rst_o` are never high together. Each strobe comes only from a completed pulse.
- R5: After a partial strobe, `ready_o` is low in the strobe cycle and stays low for exactly ceil(PART_SETUP_NS/CLK_PERIOD_NS) cycles, counted from the strobe cycle.
- R6: `ready_o` stays low for exactly ceil(FULL_SETUP_NS/CLK_PERIOD_NS) cycles in two cases: after removal of `por_n`, counted from the first clock edge after removal, and after a full strobe, counted from the strobe cycle.
- R7: `osr_sel` is captured in two cases: when a partial or full pulse ends, and at the first clock after `por_n` is removed. For codes 0 to 6, `osr_ratio_o` = 2^code (1, 2, 4, 8, 16, 32, 64) and `sw_mode_o` = 0.
- R8: A captured code 7 gives `sw_mode_o` = 1 and `osr_ratio_o` = 0.
- R9: A `start_req` sampled while `ready_o` is low makes `start_rej_o` high for the next cycle only. A `start_req` sampled while ready is high gives no reject.
- R10: The pin passes through a two-flop synchronizer. Pulse width is counted with a counter that saturates, so a very long pulse still classifies as full.
- R11: While `por_n` is low, both strobes and `start_rej_o` are low, `ready_o` is low, and the ratio reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| osr_sel | input | 3 | Oversampling select, captured at reset release |
| start_req | input | 1 | Conversion-start request |
| part_rst_o | output | 1 | One-cycle partial-reset strobe |
| full_rst_o | output | 1 | One-cycle full-reset strobe |
| ready_o | output | 1 | High once the setup holdoff has elapsed |
| osr_ratio_o | output | 7 | Decoded oversampling ratio, 0 in software mode |
| sw_mode_o | output | 1 | Software mode selected (code 7) |
| start_rej_o | output | 1 | One-cycle flag for a dropped start request |

## Verification
The hardest cases to reach are the width boundaries. A pulse one cycle under a threshold and a pulse exactly on it must land in different classes, and the pin passes through a synchronizer first. The bench therefore drives the pin on falling clock edges for an exact number of rising edges, so the synchronized width equals the driven count. It then places pulses at 4/5 and 199/200 cycles, inside the undefined band, and far past the counter's saturation point. To exercise the rejection path, a start request is issued inside a live holdoff window just after a full strobe.

// File: rtl/rstw_pkg.sv
package rstw_pkg;

  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_PART = 2'd1,
    OUT_FULL = 2'd2
  } rst_outcome_e;

  // Round a time in ns up to a whole number of clock cycles.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ns);
    return (ns + per_ns - 1) / per_ns;
  endfunction

  // Sort a measured width into an outcome; the undefined band above the
  // partial limit is treated as full.
  function automatic rst_outcome_e classify(input int unsigned width,
                                            input int unsigned min_cyc,
                                            input int unsigned lim_cyc);
    if (width < min_cyc)      return OUT_NONE;
    else if (width < lim_cyc) return OUT_PART;
    else                      return OUT_FULL;
  endfunction

  // Oversampling code to ratio; the top code carries no ratio.
  function automatic logic [6:0] osr_decode(input logic [2:0] code);
    if (code == 3'd7) return 7'd0;
    return 7'd1 << code;
  endfunction

endpackage

// File: rtl/rstw_sync.sv
module rstw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstw_width_meter.sv
module rstw_width_meter
  import rstw_pkg::*;
#(
  parameter int unsigned MIN_CYC = 5,
  parameter int unsigned LIM_CYC = 200,
  localparam int unsigned CW     = $clog2(LIM_CYC + 1)
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         rst_s,
  output logic         rel_o,
  output rst_outcome_e outcome_o
);
  logic [CW-1:0] width_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      width_q <= '0;
    end else if (rst_s) begin
      if (width_q != CW'(LIM_CYC)) width_q <= width_q + 1'b1;
    end else begin
      width_q <= '0;
    end
  end

  // Release: synchronized reset low while a measured width is pending.
  assign rel_o     = !rst_s && (width_q != '0);
  assign outcome_o = classify(32'(width_q), MIN_CYC, LIM_CYC);
endmodule

// File: rtl/rstw_holdoff.sv
module rstw_holdoff #(
  parameter int unsigned PART_CYC = 5,
  parameter int unsigned FULL_CYC = 25300,
  localparam int unsigned MAXC    = (FULL_CYC > PART_CYC) ? FULL_CYC : PART_CYC,
  localparam int unsigned HW      = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic load_part,
  input  logic load_full,
  output logic ready_o
);
  logic [HW-1:0] left_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              left_q <= HW'(FULL_CYC);
    else if (load_full)      left_q <= HW'(FULL_CYC);
    else if (load_part)      left_q <= HW'(PART_CYC);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign ready_o = (left_q == '0);
endmodule

// File: rtl/rstw_classifier.sv
module rstw_classifier
  import rstw_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS    = 10,
  parameter int unsigned IGNORE_BELOW_NS  = 50,
  parameter int unsigned PARTIAL_BELOW_NS = 2000,
  parameter int unsigned PART_SETUP_NS    = 50,
  parameter int unsigned FULL_SETUP_NS    = 253000,
  parameter int unsigned SYNC_STAGES      = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_pin,
  input  logic [2:0] osr_sel,
  input  logic       start_req,
  output logic       part_rst_o,
  output logic       full_rst_o,
  output logic       ready_o,
  output logic [6:0] osr_ratio_o,
  output logic       sw_mode_o,
  output logic       start_rej_o
);
  localparam int unsigned MIN_CYC  = ns_to_cyc(IGNORE_BELOW_NS, CLK_PERIOD_NS);
  localparam int unsigned LIM_CYC  = ns_to_cyc(PARTIAL_BELOW_NS, CLK_PERIOD_NS);
  localparam int unsigned PART_CYC = ns_to_cyc(PART_SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned FULL_CYC = ns_to_cyc(FULL_SETUP_NS, CLK_PERIOD_NS);

  // Named internal events, visible to the bound checker.
  logic         rst_s;
  logic         rel_evt;
  rst_outcome_e outcome;
  logic         take_part;
  logic         take_full;
  logic         por_seen_q;
  logic [2:0]   code_q;

  rstw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .por_n (por_n),
    .d     (rst_pin),
    .q     (rst_s)
  );

  rstw_width_meter #(.MIN_CYC(MIN_CYC), .LIM_CYC(LIM_CYC)) u_meter (
    .clk       (clk),
    .por_n     (por_n),
    .rst_s     (rst_s),
    .rel_o     (rel_evt),
    .outcome_o (outcome)
  );

  assign take_part = rel_evt && (outcome == OUT_PART);
  assign take_full = rel_evt && (outcome == OUT_FULL);

  rstw_holdoff #(.PART_CYC(PART_CYC), .FULL_CYC(FULL_CYC)) u_hold (
    .clk       (clk),
    .por_n     (por_n),
    .load_part (take_part),
    .load_full (take_full),
    .ready_o   (ready_o)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      part_rst_o  <= 1'b0;
      full_rst_o  <= 1'b0;
      start_rej_o <= 1'b0;
      por_seen_q  <= 1'b0;
      code_q      <= 3'd0;
    end else begin
      part_rst_o  <= take_part;
      full_rst_o  <= take_full;
      start_rej_o <= start_req && !ready_o;
      por_seen_q  <= 1'b1;
      if (!por_seen_q || take_part || take_full) code_q <= osr_sel;
    end
  end

  assign osr_ratio_o = osr_decode(code_q);
  assign sw_mode_o   = (code_q == 3'd7);
endmodule

// File: rtl/rstw_checker.sv
module rstw_checker (
  input logic       clk,
  input logic       por_n,
  input logic       rel_evt,
  input logic       part_rst_o,
  input logic       full_rst_o,
  input logic       ready_o,
  input logic       start_req,
  input logic       start_rej_o,
  input logic [6:0] osr_ratio_o,
  input logic       sw_mode_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!por_n)
    !(part_rst_o && full_rst_o)); // R4
  AST_STROBE_FROM_REL: assert property (@(posedge clk) disable iff (!por_n)
    (part_rst_o || full_rst_o) |-> $past(rel_evt)); // R4
  AST_PART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
    part_rst_o |=> !part_rst_o); // R2
  AST_FULL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
    full_rst_o |=> !full_rst_o); // R3
  AST_HOLD_ON_STROBE: assert property (@(posedge clk) disable iff (!por_n)
    (part_rst_o || full_rst_o) |-> !ready_o); // R5
  AST_REJ_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    start_rej_o |-> ($past(start_req) && !$past(ready_o))); // R9
  AST_SW_NO_RATIO: assert property (@(posedge clk) disable iff (!por_n)
    sw_mode_o |-> (osr_ratio_o == 7'd0)); // R8
  AST_RATIO_POW2: assert property (@(posedge clk) disable iff (!por_n)
    !sw_mode_o |-> ($countones(osr_ratio_o) == 1)); // R7
endmodule

bind rstw_classifier rstw_checker u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .rel_evt     (rel_evt),
  .part_rst_o  (part_rst_o),
  .full_rst_o  (full_rst_o),
  .ready_o     (ready_o),
  .start_req   (start_req),
  .start_rej_o (start_rej_o),
  .osr_ratio_o (osr_ratio_o),
  .sw_mode_o   (sw_mode_o)
);

// File: tb/sim_rstw_classifier.sv
module sim_rstw_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int IGN_NS  = 50;
  localparam int PART_NS = 2000;
  localparam int PSET_NS = 50;
  localparam int FSET_NS = 3000;
  // Expected cycle counts, computed by rounding up.
  localparam int MIN_C = (IGN_NS  + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int LIM_C = (PART_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int PH_C  = (PSET_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int FH_C  = (FSET_NS + CLK_PERIOD - 1) / CLK_PERIOD;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_pin = 1'b0;
  logic [2:0] osr_sel = 3'd3;
  logic start_req = 1'b0;
  logic part_rst_o, full_rst_o, ready_o, sw_mode_o, start_rej_o;
  logic [6:0] osr_ratio_o;

  int checks = 0;
  int fails  = 0;

  typedef struct { int kind; logic [2:0] code; } exp_t; // kind 1 partial, 2 full
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rstw_classifier #(
    .CLK_PERIOD_NS(CLK_PERIOD), .IGNORE_BELOW_NS(IGN_NS), .PARTIAL_BELOW_NS(PART_NS),
    .PART_SETUP_NS(PSET_NS), .FULL_SETUP_NS(FSET_NS), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .osr_sel(osr_sel), .start_req(start_req),
    .part_rst_o(part_rst_o), .full_rst_o(full_rst_o), .ready_o(ready_o),
    .osr_ratio_o(osr_ratio_o), .sw_mode_o(sw_mode_o), .start_rej_o(start_rej_o)
  );

  function automatic logic [6:0] exp_ratio(input logic [2:0] c);
    int r = 1;
    if (c == 3'd7) return 7'd0;
    for (int i = 0; i < int'(c); i++) r = r * 2;
    return 7'(r);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Driver: push the expected outcome, then drive an exact-width pulse.
  task automatic drive_pulse(input int n, input logic [2:0] code);
    exp_t e;
    @(negedge clk);
    osr_sel = code;
    if (n >= MIN_C) begin
      e.kind = (n < LIM_C) ? 1 : 2;
      e.code = code;
      sb.push_back(e);
    end
    rst_pin = 1'b1;
    repeat (n) @(negedge clk);
    rst_pin = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    while (sb.size() != 0 || !ready_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pop on each strobe and compare, then time the holdoff.
  initial begin
    forever begin
      @(negedge clk);
      if (por_n && (part_rst_o || full_rst_o)) begin
        if (sb.size() == 0) begin
          check(1'b0, "R1 unexpected strobe", 1, 0);
        end else begin
          automatic exp_t e = sb.pop_front();
          automatic int k = 0;
          automatic int hold_exp = (e.kind == 1) ? PH_C : FH_C;
          check(part_rst_o == (e.kind == 1), (e.kind == 1) ? "R2 partial strobe" : "R3 no partial",
                int'(part_rst_o), int'(e.kind == 1));
          check(full_rst_o == (e.kind == 2), (e.kind == 2) ? "R3 full strobe" : "R2 no full",
                int'(full_rst_o), int'(e.kind == 2));
          check(osr_ratio_o == exp_ratio(e.code), "R7 ratio", int'(osr_ratio_o), int'(exp_ratio(e.code)));
          check(sw_mode_o == (e.code == 3'd7), "R8 sw mode", int'(sw_mode_o), int'(e.code == 3'd7));
          check(!ready_o, "R5 ready low at strobe", int'(ready_o), 0);
          while (!ready_o) begin
            @(negedge clk);
            k++;
            if (k == 1)
              check(!part_rst_o && !full_rst_o, "R4 one-cycle strobe",
                    int'(part_rst_o | full_rst_o), 0);
          end
          check(k == hold_exp, (e.kind == 1) ? "R5 partial holdoff" : "R6 full holdoff", k, hold_exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    // R11: state held during power-on reset
    check(!part_rst_o && !full_rst_o && !start_rej_o, "R11 strobes low in reset",
          int'(part_rst_o | full_rst_o | start_rej_o), 0);
    check(!ready_o, "R11 ready low in reset", int'(ready_o), 0);
    check(osr_ratio_o == 7'd1, "R11 ratio in reset", int'(osr_ratio_o), 1);
    por_n = 1'b1;
    k = 0;
    while (!ready_o) begin @(negedge clk); k++; end
    check(k == FH_C, "R6 power-on holdoff", k, FH_C);
    check(osr_ratio_o == 7'd8 && !sw_mode_o, "R7 code captured at power-on", int'(osr_ratio_o), 8);

    // R1: too-short pulses are ignored
    drive_pulse(1, 3'd2); settle();
    drive_pulse(MIN_C - 1, 3'd6); settle();
    check(osr_ratio_o == 7'd8, "R1 ratio unchanged", int'(osr_ratio_o), 8);
    check(ready_o, "R1 ready unchanged", int'(ready_o), 1);

    // R2 / R3 boundaries, R10 saturation
    drive_pulse(MIN_C, 3'd1); settle();
    drive_pulse(LIM_C - 1, 3'd4); settle();
    drive_pulse(LIM_C, 3'd5); settle();
    drive_pulse(LIM_C + 50, 3'd7); settle();
    drive_pulse(2, 3'd0); settle();
    check(sw_mode_o && osr_ratio_o == 7'd0, "R1 sw mode kept after ignored pulse",
          int'(sw_mode_o), 1);
    drive_pulse(LIM_C * 3, 3'd0); settle();
    drive_pulse(30, 3'd6); settle();

    // R9: start rejected during holdoff, accepted once ready
    drive_pulse(LIM_C + 10, 3'd2);
    repeat (6) @(negedge clk);
    check(!ready_o, "R9 in holdoff", int'(ready_o), 0);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    check(start_rej_o, "R9 reject pulse", int'(start_rej_o), 1);
    @(negedge clk);
    check(!start_rej_o, "R9 reject one cycle", int'(start_rej_o), 0);
    settle();
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    check(!start_rej_o, "R9 accepted when ready", int'(start_rej_o), 0);
    @(negedge clk);
    check(sb.size() == 0, "R4 all expected strobes seen", sb.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule